// File: doc/BRIEF.md
# Split Code/Data Page Translation Unit

This block maps 16-bit virtual addresses onto a 22-bit physical address space in 2 KB pages. It holds two 32-entry page tables. Instruction fetches go through the code table, and loads and stores go through the data table. Each 16-bit entry has four flags and an 11-bit frame number. The flags are present, writable, memory-versus-device select and wait-state bypass. For an access, the unit produces:
- the physical address;
- a memory/device select;
- a wait-state request;
- a not-present fault and a write-protection fault.

The translation is combinational within the cycle. When the paging-enable bit of the status word is clear, the address goes through untranslated. Privileged table-write operations fill the tables, and they are accepted only when the kernel bit of the status word is set. A table write in user mode is dropped, and the unit pulses a privilege-violation flag. The access side has no valid/ready pairing, because a lookup always completes in the cycle it is presented and there is no back-pressure. `acc_valid` only qualifies the fault and wait outputs.

Top module: `page_xlate`

## Requirements
- R1: With paging on, `paddr` is the 11-bit frame field (entry bits 10..0) placed above `vaddr[10:0]`. The offset bits always equal `vaddr[10:0]`.
- R2: Access kind encoding is 0 = fetch, 1 = data read, 2 = data write (3 behaves as a read). A fetch is translated through the code table and a read or write through the data table, both indexed by `vaddr[15:11]`.
- R3: With paging on and `acc_valid` high, an access through an entry whose bit 15 is clear raises `fault_absent`.
- R4: `fault_wprot` rises only for a valid data write through a present entry whose bit 14 is clear. Fetches and reads never raise it.
- R5: With paging on, `sel_sram` equals entry bit 13 (1 = SRAM, 0 = device space).
- R6: With paging on and `acc_valid` high, `wait_req` is high exactly when entry bit 12 is clear.
- R7: When `status[7]` is 0, the unit bypasses translation. `paddr` is `vaddr` zero-extended, `sel_sram` is 1, and `wait_req` and both faults are 0.
- R8: A table write (`tw_en`) is performed only when `status[3]` is 1 (kernel). In user mode the write leaves the table unchanged, and `priv_viol` is high for exactly the following cycle.
- R9: A table write takes effect at the next clock edge. A lookup of the entry being written in the same cycle returns the old contents.
- R10: Reset clears every entry of both tables, so every page reads as not present.
- R11: With `acc_valid` low, `wait_req`, `fault_absent` and `fault_wprot` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write |
| vaddr | input | 16 | Virtual address |
| status | input | 8 | Status word; bit 7 paging enable, bit 3 kernel mode |
| tw_en | input | 1 | Table-write request |
| tw_data_tbl | input | 1 | 0 writes the code table, 1 the data table |
| tw_idx | input | 5 | Entry index to write |
| tw_entry | input | 16 | Entry value to write |
| paddr | output | 22 | Physical address |
| sel_sram | output | 1 | 1 = SRAM, 0 = device space |
| wait_req | output | 1 | Wait-state request for this access |
| fault_absent | output | 1 | Not-present fault |
| fault_wprot | output | 1 | Write-protection fault |
| priv_viol | output | 1 | One-cycle pulse after a user-mode table write |

## Verification
The bench builds the unit with its default parameters. These are 16-bit virtual addresses, an 11-bit offset and an 11-bit frame field, which give 32-entry tables and a 22-bit physical address. With these widths the bench can drive the extreme frame 0x7FF and the last offset together, and reach the top of the physical space at 0x3FFFFF. A single virtual page can be mapped differently in the two tables, which separates code lookups from data lookups. Directed steps then cover:
- the cleared state after reset;
- the untranslated path;
- the dropped user-mode write;
- the old-value-returned case when a write and a lookup of the same entry meet in one cycle.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam int ST_PAGING_BIT = 7;
  localparam int ST_KERNEL_BIT = 3;

  localparam int ENT_PRESENT_BIT = 15;
  localparam int ENT_WRITE_BIT   = 14;
  localparam int ENT_SRAM_BIT    = 13;
  localparam int ENT_NOWAIT_BIT  = 12;
endpackage

// File: rtl/pt_table.sv
module pt_table #(
  parameter int IDX_W = 5,
  parameter int ENT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

  // Without a write, a held index keeps returning the same entry.
  assert_table_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!we ##1 $stable(rd_idx)) |-> $stable(rd_data));
endmodule

// File: rtl/pt_decode.sv
module pt_decode
  import page_xlate_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int OFS_W   = 11,
  parameter int FRAME_W = 11,
  parameter int ENT_W   = 16,
  parameter int PA_W    = FRAME_W + OFS_W
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             is_write,
  input  logic             acc_valid,
  input  logic             pg_en,
  output logic [PA_W-1:0]  paddr,
  output logic             sel_sram,
  output logic             wait_req,
  output logic             fault_absent,
  output logic             fault_wprot
);
  logic present, writable;

  always_comb begin
    present  = entry[ENT_PRESENT_BIT];
    writable = entry[ENT_WRITE_BIT];
    if (pg_en) begin
      paddr        = {entry[FRAME_W-1:0], vaddr[OFS_W-1:0]};
      sel_sram     = entry[ENT_SRAM_BIT];
      wait_req     = acc_valid & ~entry[ENT_NOWAIT_BIT];
      fault_absent = acc_valid & ~present;
      fault_wprot  = acc_valid & present & is_write & ~writable;
    end else begin
      paddr        = PA_W'(vaddr);
      sel_sram     = 1'b1;
      wait_req     = 1'b0;
      fault_absent = 1'b0;
      fault_wprot  = 1'b0;
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int OFS_W   = 11,
  parameter int FRAME_W = 11,
  parameter int ENT_W   = 16,
  parameter int ST_W    = 8,
  localparam int IDX_W  = VA_W - OFS_W,
  localparam int PA_W   = FRAME_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [1:0]       acc_kind,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [ST_W-1:0]  status,
  input  logic             tw_en,
  input  logic             tw_data_tbl,
  input  logic [IDX_W-1:0] tw_idx,
  input  logic [ENT_W-1:0] tw_entry,
  output logic [PA_W-1:0]  paddr,
  output logic             sel_sram,
  output logic             wait_req,
  output logic             fault_absent,
  output logic             fault_wprot,
  output logic             priv_viol
);
  logic             kernel, pg_en, wr_ok;
  logic [1:0]       tbl_we;
  logic [ENT_W-1:0] tbl_rd [2];
  logic [ENT_W-1:0] sel_entry;
  logic [IDX_W-1:0] rd_idx;
  acc_kind_e        kind;

  assign kernel = status[ST_KERNEL_BIT];
  assign pg_en  = status[ST_PAGING_BIT];
  assign wr_ok  = tw_en & kernel;
  assign rd_idx = vaddr[VA_W-1:OFS_W];
  assign kind   = acc_kind_e'(acc_kind);

  // Index 0 is the code table, index 1 the data table.
  for (genvar t = 0; t < 2; t++) begin : g_tbl
    assign tbl_we[t] = wr_ok & (tw_data_tbl == t[0]);
    pt_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (tbl_we[t]),
      .wr_idx  (tw_idx),
      .wr_data (tw_entry),
      .rd_idx  (rd_idx),
      .rd_data (tbl_rd[t])
    );
  end

  assign sel_entry = (kind == ACC_FETCH) ? tbl_rd[0] : tbl_rd[1];

  pt_decode #(
    .VA_W(VA_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W), .ENT_W(ENT_W), .PA_W(PA_W)
  ) u_dec (
    .entry        (sel_entry),
    .vaddr        (vaddr),
    .is_write     (kind == ACC_WRITE),
    .acc_valid    (acc_valid),
    .pg_en        (pg_en),
    .paddr        (paddr),
    .sel_sram     (sel_sram),
    .wait_req     (wait_req),
    .fault_absent (fault_absent),
    .fault_wprot  (fault_wprot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) priv_viol <= 1'b0;
    else        priv_viol <= tw_en & ~kernel;
  end

  assert_user_write_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_en && !kernel) |=> priv_viol);
  assert_flag_needs_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |-> $past(tw_en && !kernel));
  assert_no_write_user_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !kernel |-> (tbl_we == 2'b00));
  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_en |-> (paddr == PA_W'(vaddr)) && sel_sram && !wait_req && !fault_absent && !fault_wprot);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !wait_req && !fault_absent && !fault_wprot);
  assert_wprot_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_wprot |-> (kind == ACC_WRITE) && !fault_absent);
  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    paddr[OFS_W-1:0] == vaddr[OFS_W-1:0]);
endmodule

// File: tb/page_xlate_test.sv
module page_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [1:0]  acc_kind;
  logic [15:0] vaddr;
  logic [7:0]  status;
  logic        tw_en, tw_data_tbl;
  logic [4:0]  tw_idx;
  logic [15:0] tw_entry;
  logic [21:0] paddr;
  logic        sel_sram, wait_req, fault_absent, fault_wprot, priv_viol;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .vaddr(vaddr), .status(status), .tw_en(tw_en), .tw_data_tbl(tw_data_tbl),
    .tw_idx(tw_idx), .tw_entry(tw_entry), .paddr(paddr), .sel_sram(sel_sram),
    .wait_req(wait_req), .fault_absent(fault_absent), .fault_wprot(fault_wprot),
    .priv_viol(priv_viol)
  );

  // {kind, vaddr, paddr, sram, wait, absent, wprot}
  localparam logic [43:0] VEC [NV] = '{
    {2'd0, 16'h0123, 22'h002923, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 fetch code e0
    {2'd1, 16'h0123, 22'h000123, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 R3 data e0 absent
    {2'd1, 16'h0812, 22'h005012, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 R6 device, waits
    {2'd2, 16'h0812, 22'h005012, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 writable
    {2'd2, 16'h1000, 22'h3FF800, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 read-only write
    {2'd1, 16'h17FF, 22'h3FFFFF, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 top of space
    {2'd0, 16'h0812, 22'h091812, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 fetch of ro page
    {2'd0, 16'h1000, 22'h000000, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 code absent
    {2'd2, 16'h1800, 22'h000000, 1'b0, 1'b1, 1'b1, 1'b0}  // R3 R4 absent write
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic twrite(input logic dtbl, input logic [4:0] idx, input logic [15:0] val);
    tw_en = 1'b1; tw_data_tbl = dtbl; tw_idx = idx; tw_entry = val;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_kind = 2'd0; vaddr = '0;
    status = 8'h88; tw_en = 1'b0; tw_data_tbl = 1'b0; tw_idx = '0; tw_entry = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: cleared tables after reset
    acc_valid = 1'b1; acc_kind = 2'd0; vaddr = 16'h0812;
    #1 check("R10 code absent after reset", fault_absent, 1);
    acc_kind = 2'd1;
    #1 check("R10 data absent after reset", fault_absent, 1);
    check("R8 no flag after reset", priv_viol, 0);
    acc_valid = 1'b0;

    // install mappings (kernel, paging on)
    twrite(1'b0, 5'd0, 16'hB005);
    twrite(1'b0, 5'd1, 16'hA123);
    twrite(1'b1, 5'd1, 16'hC00A);
    twrite(1'b1, 5'd2, 16'hB7FF);

    acc_valid = 1'b1;
    for (int i = 0; i < NV; i++) begin
      acc_kind = VEC[i][43:42];
      vaddr    = VEC[i][41:26];
      #1;
      check($sformatf("R1 paddr vec%0d", i), 32'(paddr), 32'(VEC[i][25:4]));
      check($sformatf("R5 sram vec%0d", i), sel_sram, VEC[i][3]);
      check($sformatf("R6 wait vec%0d", i), wait_req, VEC[i][2]);
      check($sformatf("R3 absent vec%0d", i), fault_absent, VEC[i][1]);
      check($sformatf("R4 wprot vec%0d", i), fault_wprot, VEC[i][0]);
      @(negedge clk);
    end

    // R11: no access presented
    acc_valid = 1'b0; acc_kind = 2'd2; vaddr = 16'h1800;
    #1 check("R11 wait idle", wait_req, 0);
    check("R11 absent idle", fault_absent, 0);
    vaddr = 16'h1000;
    #1 check("R11 wprot idle", fault_wprot, 0);
    acc_valid = 1'b1;

    // R7: paging off
    status = 8'h08; acc_kind = 2'd2; vaddr = 16'hFFFF;
    #1 check("R7 paddr bypass", 32'(paddr), 32'h0000FFFF);
    check("R7 sram bypass", sel_sram, 1);
    check("R7 wait bypass", wait_req, 0);
    check("R7 faults bypass", {fault_absent, fault_wprot}, 0);

    // R8: user-mode write dropped, flag pulses
    @(negedge clk);
    status = 8'h80;
    tw_en = 1'b1; tw_data_tbl = 1'b1; tw_idx = 5'd2; tw_entry = 16'h0000;
    @(negedge clk);
    tw_en = 1'b0;
    check("R8 flag pulse", priv_viol, 1);
    acc_kind = 2'd1; vaddr = 16'h1004;
    #1 check("R8 entry unchanged", 32'(paddr), 32'h3FF804);
    check("R8 still present", fault_absent, 0);
    @(negedge clk);
    check("R8 flag one cycle", priv_viol, 0);

    // R9: same-cycle lookup returns old entry
    status = 8'h88;
    acc_kind = 2'd1; vaddr = 16'h0812;
    tw_en = 1'b1; tw_data_tbl = 1'b1; tw_idx = 5'd1; tw_entry = 16'h8001;
    #1 check("R9 old value in write cycle", 32'(paddr), 32'h005012);
    @(negedge clk);
    tw_en = 1'b0;
    #1 check("R9 new value after edge", 32'(paddr), 32'h000812);
    check("R9 new flags", {sel_sram, wait_req}, 2'b01);
    acc_kind = 2'd0;
    #1 check("R2 code table untouched", 32'(paddr), 32'h091812);

    done = 1;
    report();
    $finish;
  end
endmodule